// File: doc/BRIEF.md
# Power-Down Entry and Wake-Up Controller

This block steps a chip into its low-power state and brings it back out. Software arms entry by writing a power-down request bit. An option input picks when entry happens. With the option clear, entry follows at once. With the option set, the block first waits for the processor to report that it has gone to sleep. While powered down, the block switches off the high-speed crystal, the internal high-speed oscillator, the PLL and the system clock. The two low-speed sources keep following their own enables.

Wake-up events come from several sources. The block passes them through a two-flop synchronizer, and they count only while the chip is powered down. A wake-up sets a sticky status flag and clears the request bit. The flag can raise an interrupt, and software clears it by writing 1. If the settle option is enabled, the system clock stays gated after wake-up for a fixed number of cycles. That number depends on which high-speed source drives the system: one count for the external crystal and a shorter one for the internal oscillator. The oscillators run again during this settle window.

Top module: `pd_wake_ctrl`

## Requirements
- R1: With the request bit set and `sleep_wait` low, the block is powered down from the clock edge after the request bit reads 1: `sys_clk_en`, `hxt_en` and `hirc_en` are all 0.
- R2: With `sleep_wait` high, the block keeps `sys_clk_en` at 1 for as long as `cpu_sleep` is low. It powers down on the edge that samples `cpu_sleep` high.
- R3: The request bit `pd_req` clears itself on the edge where the block leaves power-down. Writing 0 to it while the block waits for sleep returns the block to full run.
- R4: While powered down, `hxt_en` and `hirc_en` are 0 whatever their configuration inputs say. `lxt_en` and `lirc_en` equal their configuration inputs in every state.
- R5: With `settle_en` high, `sys_clk_en` stays 0 for XTAL_DLY cycles (default 4096) after leaving power-down when `src_xtal`=1. It stays 0 for OSC_DLY cycles (default 256) when `src_xtal`=0. During this window `hxt_en` and `hirc_en` follow their configuration inputs again.
- R6: Any bit of `wake_evt` held high is seen through two synchronizing flops. The block leaves power-down on the third rising edge after the event rises. An event seen while the block is not powered down leaves `wake_sts` at 0 and causes no state change.
- R7: `wake_sts` is set by a wake-up and cleared by a high `wake_sts_clr`. When both happen on the same edge, the set wins.
- R8: `wake_irq` is 1 exactly when `wake_sts` and `wake_irq_en` are both 1.
- R9: `pll_pd` is 1 while the request bit is set or the block is powered down. Otherwise it equals `pll_pd_cfg`.
- R10: With `settle_en` low, `sys_clk_en` returns to 1 on the same edge where the block leaves power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pd_wr | input | 1 | Write strobe for the power-down request bit |
| pd_wdata | input | 1 | Value written to the request bit |
| sleep_wait | input | 1 | 1: entry waits for CPU sleep; 0: entry is immediate |
| cpu_sleep | input | 1 | Processor reports it is in sleep |
| settle_en | input | 1 | Enables the post-wake settle delay |
| src_xtal | input | 1 | 1: system runs from external crystal; 0: from internal oscillator |
| wake_evt | input | N_WAKE | Asynchronous wake-up event sources |
| wake_irq_en | input | 1 | Wake-up interrupt enable |
| wake_sts_clr | input | 1 | Write-1-to-clear strobe for the status flag |
| hxt_en_cfg | input | 1 | Configured high-speed crystal enable |
| hirc_en_cfg | input | 1 | Configured internal high-speed oscillator enable |
| lxt_en_cfg | input | 1 | Configured low-speed crystal enable |
| lirc_en_cfg | input | 1 | Configured low-speed oscillator enable |
| pll_pd_cfg | input | 1 | Configured PLL power-down bit |
| pd_req | output | 1 | Current value of the request bit |
| hxt_en | output | 1 | High-speed crystal enable |
| hirc_en | output | 1 | Internal high-speed oscillator enable |
| lxt_en | output | 1 | Low-speed crystal enable |
| lirc_en | output | 1 | Low-speed oscillator enable |
| pll_pd | output | 1 | PLL power-down control |
| sys_clk_en | output | 1 | System clock gate, 1 = clock running |
| wake_sts | output | 1 | Sticky wake-up status flag |
| wake_irq | output | 1 | Wake-up interrupt |

## Verification
A request write shows on `pd_req` one edge after the strobe. Immediate entry gates the clock one edge after that. Waiting entry gates the clock on the edge that samples `cpu_sleep` high. A wake event driven between edges changes the status flag, the request bit and the clock gate on the third rising edge. When settling is enabled, the clock returns exactly the chosen delay in cycles after that edge. The bench drives every input at the falling edge and counts rising edges before it samples. It checks each output at the falling edge after the edge that should update it. Where a value must still be unchanged, it also checks that output one edge earlier.

// File: rtl/pd_wake_ctrl.sv
module pd_wake_ctrl #(
  parameter int XTAL_DLY = 4096,
  parameter int OSC_DLY  = 256,
  parameter int N_WAKE   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_wr,
  input  logic              pd_wdata,
  input  logic              sleep_wait,
  input  logic              cpu_sleep,
  input  logic              settle_en,
  input  logic              src_xtal,
  input  logic [N_WAKE-1:0] wake_evt,
  input  logic              wake_irq_en,
  input  logic              wake_sts_clr,
  input  logic              hxt_en_cfg,
  input  logic              hirc_en_cfg,
  input  logic              lxt_en_cfg,
  input  logic              lirc_en_cfg,
  input  logic              pll_pd_cfg,
  output logic              pd_req,
  output logic              hxt_en,
  output logic              hirc_en,
  output logic              lxt_en,
  output logic              lirc_en,
  output logic              pll_pd,
  output logic              sys_clk_en,
  output logic              wake_sts,
  output logic              wake_irq
);
  localparam int MAXD = (XTAL_DLY > OSC_DLY) ? XTAL_DLY : OSC_DLY;
  localparam int CW   = $clog2(MAXD) + 1;

  typedef enum logic [1:0] {ST_RUN, ST_WAIT, ST_DOWN, ST_SETTLE} st_t;
  st_t st;
  logic [N_WAKE-1:0] sync1, sync2;
  logic [CW-1:0]     cnt;
  logic              wake_s, wake_hit;

  assign wake_s   = |sync2;
  assign wake_hit = (st == ST_DOWN) && wake_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= wake_evt;
      sync2 <= sync1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st  <= ST_RUN;
      cnt <= '0;
    end else begin
      case (st)
        ST_RUN:
          if (pd_req) st <= sleep_wait ? ST_WAIT : ST_DOWN;
        ST_WAIT:
          if (!pd_req)        st <= ST_RUN;
          else if (cpu_sleep) st <= ST_DOWN;
        ST_DOWN:
          if (wake_s) begin
            if (settle_en) begin
              st  <= ST_SETTLE;
              cnt <= src_xtal ? CW'(XTAL_DLY - 1) : CW'(OSC_DLY - 1);
            end else begin
              st <= ST_RUN;
            end
          end
        default:
          if (cnt == '0) st <= ST_RUN;
          else           cnt <= cnt - 1'b1;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        pd_req <= 1'b0;
    else if (wake_hit) pd_req <= 1'b0;
    else if (pd_wr && st != ST_DOWN) pd_req <= pd_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            wake_sts <= 1'b0;
    else if (wake_hit)     wake_sts <= 1'b1;
    else if (wake_sts_clr) wake_sts <= 1'b0;

  assign hxt_en     = hxt_en_cfg  && (st != ST_DOWN);
  assign hirc_en    = hirc_en_cfg && (st != ST_DOWN);
  assign lxt_en     = lxt_en_cfg;
  assign lirc_en    = lirc_en_cfg;
  assign pll_pd     = pll_pd_cfg || pd_req || (st == ST_DOWN);
  assign sys_clk_en = (st == ST_RUN) || (st == ST_WAIT);
  assign wake_irq   = wake_sts && wake_irq_en;

  assert_immediate_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && pd_req && !sleep_wait) |=> (st == ST_DOWN));
  assert_hold_for_sleep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && pd_req && !cpu_sleep) |=> sys_clk_en);
  assert_req_selfclear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_DOWN && $past(st) == ST_DOWN) |-> !pd_req);
  assert_fast_sources_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DOWN) |-> (!hxt_en && !hirc_en && !sys_clk_en));
  assert_settle_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SETTLE) |-> (cnt < CW'(MAXD) && !sys_clk_en));
  assert_wake_only_in_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_sts) |-> ($past(st) == ST_DOWN));
  assert_pll_forced_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DOWN) |-> pll_pd);
endmodule

// File: tb/sim_pd_wake_ctrl.sv
module sim_pd_wake_ctrl;
  localparam int PERIOD = 10;
  localparam int XD = 4096;
  localparam int OD = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pd_wr = 0, pd_wdata = 0, sleep_wait = 0, cpu_sleep = 0, settle_en = 0, src_xtal = 0;
  logic [5:0] wake_evt = '0;
  logic wake_irq_en = 0, wake_sts_clr = 0;
  logic hxt_en_cfg = 1, hirc_en_cfg = 1, lxt_en_cfg = 0, lirc_en_cfg = 1, pll_pd_cfg = 0;
  logic pd_req, hxt_en, hirc_en, lxt_en, lirc_en, pll_pd, sys_clk_en, wake_sts, wake_irq;
  int checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;

  pd_wake_ctrl u0 (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int settle_len(input logic en, input logic xt);
    return en ? (xt ? XD : OD) : 0;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic arm(input logic ww);
    sleep_wait = ww;
    pd_wr = 1; pd_wdata = 1;
    tick(1);
    pd_wr = 0;
    chk("R3 request bit set", pd_req, 1'b1);
    chk("R9 pll forced by request", pll_pd, 1'b1);
    chk("R2 clock still running", sys_clk_en, 1'b1);
  endtask

  task automatic cycle(input logic ww, input int wait_n, input logic se, input logic xt,
                       input int src, input logic ie, input logic clr_collide);
    int d;
    settle_en = se; src_xtal = xt; wake_irq_en = ie;
    arm(ww);
    if (ww) begin
      tick(wait_n);
      chk("R2 waits for sleep", sys_clk_en, 1'b1);
      cpu_sleep = 1;
      tick(1);
      cpu_sleep = 0;
    end else begin
      tick(1);
    end
    chk("R1 clock gated", sys_clk_en, 1'b0);
    chk("R4 crystal off", hxt_en, 1'b0);
    chk("R4 oscillator off", hirc_en, 1'b0);
    chk("R4 low-speed crystal follows cfg", lxt_en, lxt_en_cfg);
    chk("R4 low-speed osc follows cfg", lirc_en, lirc_en_cfg);
    chk("R9 pll off in power-down", pll_pd, 1'b1);
    wake_evt[src] = 1;
    tick(2);
    chk("R6 not yet awake after two edges", sys_clk_en, 1'b0);
    chk("R6 status still clear", wake_sts, 1'b0);
    wake_sts_clr = clr_collide;
    tick(1);
    wake_sts_clr = 0;
    wake_evt = '0;
    chk("R6 R7 status set on wake", wake_sts, 1'b1);
    chk("R3 request self-cleared", pd_req, 1'b0);
    chk("R8 irq follows enable", wake_irq, ie);
    d = settle_len(se, xt);
    if (d == 0) begin
      chk("R10 clock back at once", sys_clk_en, 1'b1);
    end else begin
      chk("R5 oscillators on in settle", hxt_en, hxt_en_cfg);
      tick(d - 1);
      chk("R5 clock held through settle", sys_clk_en, 1'b0);
      tick(1);
      chk("R5 clock released after settle", sys_clk_en, 1'b1);
    end
    chk("R9 pll follows cfg after wake", pll_pd, pll_pd_cfg);
    wake_sts_clr = 1;
    tick(1);
    wake_sts_clr = 0;
    chk("R7 status cleared", wake_sts, 1'b0);
    chk("R8 irq low after clear", wake_irq, 1'b0);
    tick(3);
  endtask

  initial begin
    tick(2);
    chk("R3 reset request", pd_req, 1'b0);
    chk("R10 reset clock running", sys_clk_en, 1'b1);
    chk("R7 reset status", wake_sts, 1'b0);
    rst_n = 1;
    tick(1);
    chk("R9 pll follows cfg idle", pll_pd, 1'b0);
    wake_evt = 6'b000100;
    tick(5);
    wake_evt = '0;
    tick(3);
    chk("R6 wake outside power-down ignored", wake_sts, 1'b0);
    chk("R6 no state change", sys_clk_en, 1'b1);
    arm(1'b1);
    tick(4);
    pd_wr = 1; pd_wdata = 0;
    tick(1);
    pd_wr = 0;
    chk("R3 request cleared by write", pd_req, 1'b0);
    cpu_sleep = 1;
    tick(2);
    cpu_sleep = 0;
    chk("R3 back to run after clear", sys_clk_en, 1'b1);
    cycle(1'b0, 0, 1'b0, 1'b0, 0, 1'b1, 1'b0);
    cycle(1'b1, 5, 1'b1, 1'b1, 3, 1'b1, 1'b1);
    cycle(1'b0, 0, 1'b1, 1'b0, 5, 1'b0, 1'b0);
    void'($urandom(32'd1234));
    for (int i = 0; i < 12; i++) begin
      hxt_en_cfg = 1'($urandom); hirc_en_cfg = 1'($urandom);
      lxt_en_cfg = 1'($urandom); lirc_en_cfg = 1'($urandom);
      cycle(1'($urandom), 1 + ($urandom % 7), 1'($urandom), 1'($urandom),
            $urandom % 6, 1'($urandom), 1'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 190000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule